// File: doc/BRIEF.md
# Multi-Source Acquisition Trigger Selector

This block issues the single trigger pulse that an acquisition controller waits on. A set of mode control bits chooses where the trigger comes from. The first option is no source at all: the block triggers as soon as it is armed. The other options are an external pulse line, a software strobe, or a threshold crossing on one of several sample channels. For the crossing source, the selected channel's samples are compared with a threshold. The compare result passes through a consecutive-sample glitch filter, and a polarity bit picks which direction of the filtered change counts as a crossing.

Once a source event is seen, a programmable delay counts down and then the trigger pulse goes out. The acquisition controller arms the block with a one-cycle request. After a trigger has been issued, the block stays quiet until the controller arms it again.

Top module: `trig_source_sel`

## Requirements
- R1: After reset `trigOut` is 0 and the block is unarmed. No source event produces a trigger until `armReq` has been pulsed.
- R2: With `acqNow`=1, `hwEn`=0 and `swEn`=0 (skip mode), arming is itself the event. If `armReq` is high in cycle t and `delayCnt`=0, then `trigOut` is 1 in cycle t+2.
- R3: With `acqNow`=1 together with `hwEn`=1 or `swEn`=1, no source is selected and no trigger is issued.
- R4: With `acqNow`=0, `hwEn`=1 and `hwSel`=1, the event is a 0-to-1 transition of `extPulse`. A line held high produces no further event.
- R5: With `acqNow`=0, `hwEn`=1 and `hwSel`=0, the event comes from lane `chanIdx` of `sampleBus`. Lane k occupies bits [k*32 +: 32]. The raw compare result is 1 when that lane, taken as unsigned, is strictly greater than `threshold`.
- R6: With `polarity`=0, a filtered compare change from 0 to 1 is an event. With `polarity`=1, only a change from 1 to 0 is an event.
- R7: The filtered compare state is 0 after reset and is tracked whether or not the block is armed. It takes the raw value on the (`filterLen`+1)-th consecutive valid sample that disagrees with it. A valid sample that agrees with it restarts the run. A cycle with `sampleValid`=0 neither counts toward the run nor breaks it.
- R8: With `acqNow`=0, `hwEn`=0 and `swEn`=1, a high `swStrobe` is an event. `swStrobe` is ignored when `swEn`=0, and also when `hwEn`=1, because the hardware source takes priority.
- R9: An event in cycle t while armed produces `trigOut`=1 in cycle t+1+`delayCnt`. Events seen while the delay is running are ignored.
- R10: Only one trigger is issued per arming. `armReq` while armed or while the delay is running restarts the wait and cancels the pending trigger.
- R11: `trigOut` is high for exactly one cycle per trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| armReq | input | 1 | One-cycle arming request from the acquisition controller |
| acqNow | input | 1 | Acquire immediately on arming (skip mode) |
| hwEn | input | 1 | Hardware source enable |
| hwSel | input | 1 | Hardware source choice: 1 external pulse, 0 threshold crossing |
| swEn | input | 1 | Software strobe enable |
| extPulse | input | 1 | External trigger line |
| swStrobe | input | 1 | Software trigger strobe |
| sampleBus | input | 128 | Four packed 32-bit channel samples |
| sampleValid | input | 1 | Samples on `sampleBus` are valid this cycle |
| threshold | input | 32 | Crossing threshold (unsigned) |
| polarity | input | 1 | 0 rising crossing, 1 falling crossing |
| filterLen | input | 8 | Glitch filter length in valid samples |
| chanIdx | input | 2 | Lane used for the crossing compare |
| delayCnt | input | 32 | Cycles added between event and trigger |
| trigOut | output | 1 | One-cycle trigger pulse |

## Verification
The properties assume that `armReq` is a single-cycle request. They also assume that the mode bits and `delayCnt` do not change in the cycle after an arming request. The skip and conflict checks rely on that window. The stimulus changes configuration only while the block is idle, or before it issues a fresh arming pulse, and it drives `armReq` for one cycle at a time. Source events are placed only after the arming cycle, so the cycle-exact expectations for trigger timing hold.

// File: rtl/trig_pkg.sv
`timescale 1ns/1ps
package trig_pkg;

  typedef enum logic [1:0] {
    SRC_SKIP = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_DATA = 2'd2,
    SRC_SW   = 2'd3
  } srcKind_e;

  typedef struct packed {
    logic     valid;
    srcKind_e kind;
  } srcSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadDly;
    logic runDly;
  } dlyCmd_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_WAIT  = 2'd2
  } ctlState_e;

  // Mode decode: immediate acquisition needs both other enables clear;
  // the hardware enable outranks the software enable.
  function automatic srcSel_t decodeSrc(input logic acqNow, input logic hwEn,
                                        input logic hwSel, input logic swEn);
    srcSel_t s;
    s.valid = 1'b0;
    s.kind  = SRC_SKIP;
    if (acqNow) begin
      s.valid = !hwEn && !swEn;
      s.kind  = SRC_SKIP;
    end else if (hwEn) begin
      s.valid = 1'b1;
      s.kind  = hwSel ? SRC_EXT : SRC_DATA;
    end else if (swEn) begin
      s.valid = 1'b1;
      s.kind  = SRC_SW;
    end
    return s;
  endfunction

endpackage

// File: rtl/trig_filter.sv
`timescale 1ns/1ps
module trig_filter #(
  parameter int DW = 32,
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] sample,
  input  logic          sampleValid,
  input  logic [DW-1:0] threshold,
  input  logic [FW-1:0] filterLen,
  input  logic          polarity,
  output logic          crossHit
);
  logic          rawAbove;
  logic          filtState;
  logic [FW-1:0] runLen;
  logic          differs;
  logic          flipNow;

  assign rawAbove = sample > threshold;
  assign differs  = sampleValid && (rawAbove != filtState);
  assign flipNow  = differs && (runLen >= filterLen);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      filtState <= 1'b0;
      runLen    <= '0;
    end else if (sampleValid) begin
      if (flipNow) begin
        filtState <= rawAbove;
        runLen    <= '0;
      end else if (differs) begin
        runLen <= runLen + 1'b1;
      end else begin
        runLen <= '0;
      end
    end
  end

  // polarity 0: new state 1 counts; polarity 1: new state 0 counts
  assign crossHit = flipNow && (rawAbove == !polarity);

endmodule

// File: rtl/trig_datapath.sv
`timescale 1ns/1ps
module trig_datapath
  import trig_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int DW   = 32,
  parameter int FW   = 8,
  parameter int DLYW = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  srcSel_t           srcSel,
  input  logic              extPulse,
  input  logic              swStrobe,
  input  logic [NCH*DW-1:0] sampleBus,
  input  logic              sampleValid,
  input  logic [DW-1:0]     threshold,
  input  logic              polarity,
  input  logic [FW-1:0]     filterLen,
  input  logic [CHW-1:0]    chanIdx,
  input  logic [DLYW-1:0]   delayCnt,
  input  dlyCmd_t           cmd,
  output logic              srcHit,
  output logic              dlyZero,
  output logic              dlyLast
);
  logic [DW-1:0]   lane [NCH];
  logic [DW-1:0]   selSample;
  logic            extPrev;
  logic            extEdge;
  logic            crossHit;
  logic [DLYW-1:0] dlyLeft;

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    assign lane[g] = sampleBus[g*DW +: DW];
  end

  assign selSample = lane[chanIdx];

  trig_filter #(.DW(DW), .FW(FW)) u_filt (
    .clk        (clk),
    .rstN       (rstN),
    .sample     (selSample),
    .sampleValid(sampleValid),
    .threshold  (threshold),
    .filterLen  (filterLen),
    .polarity   (polarity),
    .crossHit   (crossHit)
  );

  always_ff @(posedge clk) begin
    if (!rstN) extPrev <= 1'b0;
    else       extPrev <= extPulse;
  end
  assign extEdge = extPulse && !extPrev;

  always_comb begin
    srcHit = 1'b0;
    if (srcSel.valid) begin
      case (srcSel.kind)
        SRC_SKIP: srcHit = 1'b1;
        SRC_EXT:  srcHit = extEdge;
        SRC_DATA: srcHit = crossHit;
        SRC_SW:   srcHit = swStrobe;
        default:  srcHit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            dlyLeft <= '0;
    else if (cmd.loadDly) dlyLeft <= delayCnt;
    else if (cmd.runDly)  dlyLeft <= dlyLeft - 1'b1;
  end

  assign dlyZero = (delayCnt == '0);
  assign dlyLast = (dlyLeft == DLYW'(1));

endmodule

// File: rtl/trig_ctrl.sv
`timescale 1ns/1ps
module trig_ctrl
  import trig_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    armReq,
  input  logic    srcHit,
  input  logic    dlyZero,
  input  logic    dlyLast,
  output dlyCmd_t cmd,
  output logic    trigOut
);
  ctlState_e state, nxt;
  logic      fire;

  always_comb begin
    nxt = state;
    fire = 1'b0;
    cmd = '0;
    case (state)
      ST_IDLE: if (armReq) nxt = ST_ARMED;
      ST_ARMED: begin
        if (armReq) begin
          nxt = ST_ARMED;
        end else if (srcHit) begin
          if (dlyZero) begin
            fire = 1'b1;
            nxt  = ST_IDLE;
          end else begin
            cmd.loadDly = 1'b1;
            nxt         = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (armReq) begin
          nxt = ST_ARMED;
        end else if (dlyLast) begin
          fire = 1'b1;
          nxt  = ST_IDLE;
        end else begin
          cmd.runDly = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      trigOut <= 1'b0;
    end else begin
      state   <= nxt;
      trigOut <= fire;
    end
  end

endmodule

// File: rtl/trig_source_sel.sv
`timescale 1ns/1ps
module trig_source_sel
  import trig_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int DW   = 32,
  parameter int FW   = 8,
  parameter int DLYW = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              armReq,
  input  logic              acqNow,
  input  logic              hwEn,
  input  logic              hwSel,
  input  logic              swEn,
  input  logic              extPulse,
  input  logic              swStrobe,
  input  logic [NCH*DW-1:0] sampleBus,
  input  logic              sampleValid,
  input  logic [DW-1:0]     threshold,
  input  logic              polarity,
  input  logic [FW-1:0]     filterLen,
  input  logic [CHW-1:0]    chanIdx,
  input  logic [DLYW-1:0]   delayCnt,
  output logic              trigOut
);
  srcSel_t srcSel;
  dlyCmd_t cmd;
  logic    srcHit;
  logic    dlyZero;
  logic    dlyLast;

  assign srcSel = decodeSrc(acqNow, hwEn, hwSel, swEn);

  trig_datapath #(.NCH(NCH), .DW(DW), .FW(FW), .DLYW(DLYW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .srcSel     (srcSel),
    .extPulse   (extPulse),
    .swStrobe   (swStrobe),
    .sampleBus  (sampleBus),
    .sampleValid(sampleValid),
    .threshold  (threshold),
    .polarity   (polarity),
    .filterLen  (filterLen),
    .chanIdx    (chanIdx),
    .delayCnt   (delayCnt),
    .cmd        (cmd),
    .srcHit     (srcHit),
    .dlyZero    (dlyZero),
    .dlyLast    (dlyLast)
  );

  trig_ctrl u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .armReq (armReq),
    .srcHit (srcHit),
    .dlyZero(dlyZero),
    .dlyLast(dlyLast),
    .cmd    (cmd),
    .trigOut(trigOut)
  );

endmodule

// File: rtl/trig_checker.sv
`timescale 1ns/1ps
module trig_checker #(
  parameter int DLYW = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            armReq,
  input logic            acqNow,
  input logic            hwEn,
  input logic            swEn,
  input logic [DLYW-1:0] delayCnt,
  input logic            trigOut
);
  logic skipOk;
  logic conflict;
  logic spent;

  assign skipOk   = acqNow && !hwEn && !swEn && (delayCnt == '0);
  assign conflict = acqNow && (hwEn || swEn);

  // set while no trigger is owed: from reset until an arm, and after a trigger
  always_ff @(posedge clk) begin
    if (!rstN)        spent <= 1'b1;
    else if (armReq)  spent <= 1'b0;
    else if (trigOut) spent <= 1'b1;
  end

  a_r10_one_per_arm: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> !spent);

  a_r11_pulse_width: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |=> !trigOut);

  a_r2_skip_fires: assert property (@(posedge clk) disable iff (!rstN)
    (armReq && skipOk) ##1 (!armReq && skipOk) |=> trigOut);

  a_r3_conflict_silent: assert property (@(posedge clk) disable iff (!rstN)
    ($past(armReq) && $past(conflict) && conflict && !armReq) |=> !trigOut);

endmodule

bind trig_source_sel trig_checker #(.DLYW(DLYW)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .armReq  (armReq),
  .acqNow  (acqNow),
  .hwEn    (hwEn),
  .swEn    (swEn),
  .delayCnt(delayCnt),
  .trigOut (trigOut)
);

// File: tb/sim_trig_source_sel.sv
`timescale 1ns/1ps
module sim_trig_source_sel;
  localparam int NCH  = 4;
  localparam int DW   = 32;
  localparam int FW   = 8;
  localparam int DLYW = 32;
  localparam int NVEC = 17;

  // {armReq, sampleValid, lane-2 sample, expected trigOut}
  localparam logic [34:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 32'd0,   1'b0},
    {1'b0, 1'b1, 32'd200, 1'b0},
    {1'b0, 1'b0, 32'd200, 1'b0},
    {1'b0, 1'b1, 32'd200, 1'b0},
    {1'b0, 1'b1, 32'd50,  1'b0},
    {1'b0, 1'b1, 32'd200, 1'b0},
    {1'b0, 1'b1, 32'd200, 1'b0},
    {1'b0, 1'b1, 32'd200, 1'b1},
    {1'b0, 1'b1, 32'd50,  1'b0},
    {1'b0, 1'b1, 32'd50,  1'b0},
    {1'b0, 1'b1, 32'd50,  1'b0},
    {1'b1, 1'b0, 32'd0,   1'b0},
    {1'b0, 1'b1, 32'd100, 1'b0},
    {1'b0, 1'b1, 32'd101, 1'b0},
    {1'b0, 1'b1, 32'd101, 1'b0},
    {1'b0, 1'b1, 32'd101, 1'b1},
    {1'b0, 1'b1, 32'd101, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rstN, armReq, acqNow, hwEn, hwSel, swEn;
  logic              extPulse, swStrobe, sampleValid, polarity;
  logic [NCH*DW-1:0] sampleBus;
  logic [DW-1:0]     threshold;
  logic [FW-1:0]     filterLen;
  logic [1:0]        chanIdx;
  logic [DLYW-1:0]   delayCnt;
  logic              trigOut;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  trig_source_sel u0 (
    .clk(clk), .rstN(rstN), .armReq(armReq), .acqNow(acqNow), .hwEn(hwEn),
    .hwSel(hwSel), .swEn(swEn), .extPulse(extPulse), .swStrobe(swStrobe),
    .sampleBus(sampleBus), .sampleValid(sampleValid), .threshold(threshold),
    .polarity(polarity), .filterLen(filterLen), .chanIdx(chanIdx),
    .delayCnt(delayCnt), .trigOut(trigOut)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: trigOut=%b expected %b", req, act, exp);
    end
  endtask

  task automatic cfg(input logic a, input logic he, input logic hs, input logic se);
    acqNow = a; hwEn = he; hwSel = hs; swEn = se;
  endtask

  task automatic setLane(input logic [DW-1:0] v);
    for (int k = 0; k < NCH; k++)
      sampleBus[k*DW +: DW] = (k == 2) ? v : DW'(1000);
  endtask

  task automatic armIt();
    armReq = 1'b1;
    tick();
    armReq = 1'b0;
  endtask

  task automatic quiet(input string req, input int n);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (trigOut) seen++;
    end
    chk(req, seen != 0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; armReq = 1'b0; cfg(0, 0, 0, 0);
    extPulse = 1'b0; swStrobe = 1'b0; sampleValid = 1'b0; polarity = 1'b0;
    setLane(32'd0); threshold = 32'd100; filterLen = 8'd2; chanIdx = 2'd2;
    delayCnt = '0;
    repeat (3) tick();
    chk("R1 reset", trigOut, 1'b0);
    rstN = 1'b1;
    tick();

    // R1: external edge before any arming does nothing
    cfg(0, 1, 1, 0);
    extPulse = 1'b1;
    tick();
    chk("R1 unarmed", trigOut, 1'b0);
    extPulse = 1'b0;
    tick();

    // R4 / R11 / R10 external edge
    armIt();
    extPulse = 1'b1; tick();
    chk("R4 ext edge", trigOut, 1'b1);
    tick();
    chk("R11 one cycle", trigOut, 1'b0);
    extPulse = 1'b0; tick();
    extPulse = 1'b1; tick();
    chk("R10 no rearm", trigOut, 1'b0);
    armIt();
    tick();
    chk("R4 level held", trigOut, 1'b0);
    extPulse = 1'b0; tick();
    extPulse = 1'b1; tick();
    chk("R4 new edge", trigOut, 1'b1);
    extPulse = 1'b0; tick();

    // R9 delay of 3
    delayCnt = 32'd3;
    armIt();
    extPulse = 1'b1; tick();
    chk("R9 t+1", trigOut, 1'b0);
    extPulse = 1'b0; tick();
    chk("R9 t+2", trigOut, 1'b0);
    tick();
    chk("R9 t+3", trigOut, 1'b0);
    tick();
    chk("R9 t+4", trigOut, 1'b1);

    // R10 re-arm cancels a running delay
    armIt();
    extPulse = 1'b1; tick();
    extPulse = 1'b0;
    armIt();
    quiet("R10 cancel", 6);
    delayCnt = '0;

    // R2 skip mode
    cfg(1, 0, 0, 0);
    armIt();
    chk("R2 arm cycle", trigOut, 1'b0);
    tick();
    chk("R2 skip fires", trigOut, 1'b1);
    tick();
    chk("R11 skip width", trigOut, 1'b0);

    // R3 conflicting enables
    cfg(1, 0, 0, 1);
    armIt();
    swStrobe = 1'b1; tick(); swStrobe = 1'b0;
    quiet("R3 conflict", 4);

    // R8 software strobe
    cfg(0, 0, 0, 1);
    armIt();
    swStrobe = 1'b1; tick(); swStrobe = 1'b0;
    chk("R8 sw strobe", trigOut, 1'b1);
    cfg(0, 0, 0, 0);
    armIt();
    swStrobe = 1'b1; tick(); swStrobe = 1'b0;
    chk("R8 sw disabled", trigOut, 1'b0);
    cfg(0, 1, 1, 1);
    swStrobe = 1'b1; tick(); swStrobe = 1'b0;
    chk("R8 hw priority", trigOut, 1'b0);
    extPulse = 1'b1; tick(); extPulse = 1'b0;
    chk("R8 hw source", trigOut, 1'b1);
    tick();

    // R5 / R7 table: crossing on lane 2, threshold 100, filter 2, rising
    cfg(0, 1, 0, 0);
    for (int v = 0; v < NVEC; v++) begin
      armReq      = VEC[v][34];
      sampleValid = VEC[v][33];
      setLane(VEC[v][32:1]);
      tick();
      chk($sformatf("R7/R5 row %0d", v), trigOut, VEC[v][0]);
    end
    armReq = 1'b0;

    // R6 falling polarity, filter 0 (filtered state is now 1)
    polarity  = 1'b1;
    filterLen = 8'd0;
    sampleValid = 1'b0;
    armIt();
    sampleValid = 1'b1; setLane(32'd50); tick();
    chk("R6 falling hit", trigOut, 1'b1);
    sampleValid = 1'b0;
    armIt();
    sampleValid = 1'b1; setLane(32'd200); tick();
    chk("R6 rising ignored", trigOut, 1'b0);
    setLane(32'd50); tick();
    chk("R6 falling again", trigOut, 1'b1);
    sampleValid = 1'b0;
    tick();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule